// File: doc/BRIEF.md
# UART Receive Buffer and Line Status Logic

This block sits between a UART's serial receiver, its serial transmitter and a register bus. Each character the receiver finishes arrives with three error tags (parity, framing, break) and is stored together with those tags in a receive queue. Software takes characters from the queue by reading the data location, and learns about the line by reading a status word at the status location. The same data location, when written, loads the transmit holding register. The transmitter fetches it into its shift register with a load pulse and reports the end of the character with a done pulse.

The status word reports the following: whether data is waiting, whether a character was lost, and the error tags of the character at the head of the queue. It also shows the occupancy of the transmit holding and shift registers, and a summary flag that stays up while any tagged character is still queued. A status read clears the sticky bits. The head-entry tags are cleared only for the entry that was just reported. The summary flag clears only once the queue holds no tagged character. With queue mode off, the buffer holds a single character and the summary flag reads 0.

Top module: `uart_line_status`

## Requirements
- R1: After reset the status word (address 1) reads 0x00000060, a data read (address 0) returns 0, any other address reads 0, and status bits 31:8 always read 0.
- R2: Status bit 0 is 1 exactly when the receive queue holds a character. A read of address 0 returns the oldest character in its low 8 bits and removes it, so characters come out in arrival order.
- R3: A character offered while the queue holds its capacity (FIFO_DEPTH entries in queue mode, 1 otherwise) is dropped and sets status bit 1. Bit 1 stays set until a status read.
- R4: Status bits 2 (parity), 3 (framing) and 4 (break) show the tags of the character at the queue head, not those of the newest character. A status read clears them for that head entry only, and the next entry shows its own tags once it reaches the head.
- R5: Status bit 5 is cleared by a write to address 0, which places the written byte on tx_thr_data with tx_thr_valid high. The bit is set again when the transmitter pulses tx_load while the holding register is full.
- R6: Status bit 6 is 1 only when the holding register is empty and the shift register is idle. A tx_load marks the shift register busy until a tx_done pulse.
- R7: Status bit 7 is set when a tagged character enters the queue. A status read clears it only if no tagged character remains in the queue. Otherwise it stays set.
- R8: With fifo_en low, status bit 7 reads 0 and the queue capacity is one character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Queue mode enable (1: FIFO_DEPTH entries, 0: one entry) |
| reg_addr | input | ADDR_W | Register address (0 data, 1 status) |
| reg_rd | input | 1 | Read strobe; rdata is valid in the same cycle |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data for the transmit holding register |
| reg_rdata | output | 32 | Read data |
| rx_valid | input | 1 | Receiver presents a finished character |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Character has a parity error |
| rx_ferr | input | 1 | Character has a framing error |
| rx_brk | input | 1 | Character is a break |
| tx_load | input | 1 | Transmitter takes the holding register into its shift register |
| tx_done | input | 1 | Transmitter finished shifting the current character |
| tx_thr_valid | output | 1 | Holding register contains a byte |
| tx_thr_data | output | 8 | Holding register byte |

## Verification
The hardest situation to reach is a status read that leaves bit 7 set while the queue head itself is clean. Tagged characters must still sit behind the head, and a later read must clear the bit only after the last tagged one has been taken out. A stimulus table queues clean and tagged characters in mixed orders, then interleaves status and data reads. Each status read therefore lands with a known number of tagged characters left. The table also checks that a second status read on the same head shows its tags cleared. Directed runs fill the queue past capacity, step the transmit handshake through every holding/shift occupancy pair, and repeat the tag case with queue mode off.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
    localparam int unsigned CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    // Status word bit positions
    localparam int unsigned ST_DR   = 0;
    localparam int unsigned ST_OE   = 1;
    localparam int unsigned ST_PE   = 2;
    localparam int unsigned ST_FE   = 3;
    localparam int unsigned ST_BI   = 4;
    localparam int unsigned ST_THRE = 5;
    localparam int unsigned ST_TEMT = 6;
    localparam int unsigned ST_RXER = 7;

    // Register map
    localparam int unsigned ADDR_DATA = 0;
    localparam int unsigned ADDR_STAT = 1;
endpackage

// File: rtl/lsr_rx_fifo.sv
module lsr_rx_fifo
    import uart_lsr_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cap_one,
    input  logic      push_req,
    input  rx_entry_t push_entry,
    input  logic      pop_req,
    output rx_entry_t head,
    output logic      empty,
    output logic      push_ok,
    output logic      push_tagged,
    output logic      popped,
    output logic      err_any
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]      wr_ptr;
        logic [PTR_W-1:0]      rd_ptr;
        logic [CNT_W-1:0]      count;
        logic [CNT_W-1:0]      err_cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    logic [CNT_W-1:0] cap;
    logic             do_pop;
    logic             do_push;
    logic             in_tagged;
    logic             head_tagged;

    always_comb begin
        cap         = cap_one ? CNT_W'(1) : CNT_W'(DEPTH);
        head        = st_q.mem[st_q.rd_ptr];
        empty       = (st_q.count == '0);
        do_pop      = pop_req && !empty;
        do_push     = push_req && ((st_q.count < cap) || do_pop);
        in_tagged   = push_entry.perr | push_entry.ferr | push_entry.brk;
        head_tagged = head.perr | head.ferr | head.brk;
        push_ok     = do_push;
        push_tagged = do_push && in_tagged;
        popped      = do_pop;
        err_any     = (st_q.err_cnt != '0);

        st_d = st_q;
        if (do_push) begin
            st_d.mem[st_q.wr_ptr] = push_entry;
            st_d.wr_ptr           = ptr_inc(st_q.wr_ptr);
        end
        if (do_pop) begin
            st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
        end
        st_d.count = st_q.count + CNT_W'(do_push) - CNT_W'(do_pop);
        st_d.err_cnt = st_q.err_cnt + CNT_W'(do_push && in_tagged)
                                    - CNT_W'(do_pop && head_tagged);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));

    assert_err_le_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err_cnt <= st_q.count);

    assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push && !do_pop) |=> (st_q.count == $past(st_q.count) + CNT_W'(1)));
endmodule

// File: rtl/lsr_tx_track.sv
module lsr_tx_track
    import uart_lsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_wr,
    input  logic [CHAR_W-1:0] thr_wdata,
    input  logic              tx_load,
    input  logic              tx_done,
    output logic              thr_full,
    output logic              tsr_busy,
    output logic [CHAR_W-1:0] thr_data
);
    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              full;
        logic              busy;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      take;

    always_comb begin
        take = tx_load && st_q.full;
        st_d = st_q;
        if (thr_wr) begin
            st_d.data = thr_wdata;
            st_d.full = 1'b1;
        end else if (take) begin
            st_d.full = 1'b0;
        end
        if (take)         st_d.busy = 1'b1;
        else if (tx_done) st_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign thr_full = st_q.full;
    assign tsr_busy = st_q.busy;
    assign thr_data = st_q.data;

    assert_thr_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (thr_full && thr_data == $past(thr_wdata)));

    assert_shift_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !(tx_load && thr_full)) |=> !tsr_busy);
endmodule

// File: rtl/lsr_flags.sv
module lsr_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic head_valid,
    input  logic popped,
    input  logic overrun,
    input  logic push_tagged,
    input  logic err_any,
    output logic oe_flag,
    output logic head_ack,
    output logic err_flag
);
    typedef struct packed {
        logic oe;
        logic ack;
        logic err;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (overrun)      st_d.oe = 1'b1;
        else if (stat_rd) st_d.oe = 1'b0;

        if (popped || !head_valid)      st_d.ack = 1'b0;
        else if (stat_rd)               st_d.ack = 1'b1;

        if (push_tagged)                st_d.err = 1'b1;
        else if (stat_rd && !err_any)   st_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oe_flag  = st_q.oe;
    assign head_ack = st_q.ack;
    assign err_flag = st_q.err;

    assert_oe_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> oe_flag);

    assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && err_any) |=> err_flag);

    assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_tagged |=> err_flag);
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
    import uart_lsr_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned ADDR_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              tx_load,
    input  logic              tx_done,
    output logic              tx_thr_valid,
    output logic [7:0]        tx_thr_data
);
    logic      sel_data, sel_stat;
    logic      data_rd, stat_rd, thr_wr;
    rx_entry_t in_entry, head;
    logic      empty, push_ok, push_tagged, popped, err_any;
    logic      thr_full, tsr_busy;
    logic      oe_flag, head_ack, err_flag;
    logic      overrun;
    logic      tags_on;
    logic [7:0] status;

    always_comb begin
        sel_data = (reg_addr == ADDR_W'(ADDR_DATA));
        sel_stat = (reg_addr == ADDR_W'(ADDR_STAT));
        data_rd  = reg_rd && sel_data;
        stat_rd  = reg_rd && sel_stat;
        thr_wr   = reg_wr && sel_data;
        in_entry = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};
        overrun  = rx_valid && !push_ok;
    end

    lsr_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_one     (!fifo_en),
        .push_req    (rx_valid),
        .push_entry  (in_entry),
        .pop_req     (data_rd),
        .head        (head),
        .empty       (empty),
        .push_ok     (push_ok),
        .push_tagged (push_tagged),
        .popped      (popped),
        .err_any     (err_any)
    );

    lsr_tx_track u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_wr    (thr_wr),
        .thr_wdata (reg_wdata),
        .tx_load   (tx_load),
        .tx_done   (tx_done),
        .thr_full  (thr_full),
        .tsr_busy  (tsr_busy),
        .thr_data  (tx_thr_data)
    );

    lsr_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_rd     (stat_rd),
        .head_valid  (!empty),
        .popped      (popped),
        .overrun     (overrun),
        .push_tagged (push_tagged),
        .err_any     (err_any),
        .oe_flag     (oe_flag),
        .head_ack    (head_ack),
        .err_flag    (err_flag)
    );

    always_comb begin
        tags_on          = !empty && !head_ack;
        status           = '0;
        status[ST_DR]    = !empty;
        status[ST_OE]    = oe_flag;
        status[ST_PE]    = tags_on && head.perr;
        status[ST_FE]    = tags_on && head.ferr;
        status[ST_BI]    = tags_on && head.brk;
        status[ST_THRE]  = !thr_full;
        status[ST_TEMT]  = !thr_full && !tsr_busy;
        status[ST_RXER]  = fifo_en && err_flag;

        reg_rdata = '0;
        if (reg_rd && sel_stat)              reg_rdata = {24'd0, status};
        else if (reg_rd && sel_data && !empty) reg_rdata = {24'd0, head.data};
    end

    assign tx_thr_valid = thr_full;

    assert_temt_needs_thre_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_TEMT] |-> status[ST_THRE]);

    assert_dr_after_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && empty) |=> status[ST_DR]);

    assert_fifo_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !fifo_en) |-> !reg_rdata[ST_RXER]);

    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:8] == 24'd0);
endmodule

// File: tb/uart_line_status_bench.sv
module uart_line_status_bench;
    localparam int ADDR_W = 2;
    localparam int NVEC   = 21;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fifo_en = 1'b1;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_rd = 1'b0;
    logic              reg_wr = 1'b0;
    logic [7:0]        reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
    logic              tx_load = 1'b0, tx_done = 1'b0;
    logic              tx_thr_valid;
    logic [7:0]        tx_thr_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    uart_line_status #(.FIFO_DEPTH(8), .ADDR_W(ADDR_W)) u_uart_line_status (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
        .tx_load(tx_load), .tx_done(tx_done),
        .tx_thr_valid(tx_thr_valid), .tx_thr_data(tx_thr_data)
    );

    // op: 0 push, 1 status read, 2 data read; tag = {brk, ferr, perr}
    localparam logic [20:0] VEC [NVEC] = '{
        {2'd0, 8'h11, 3'b000, 8'h00},
        {2'd0, 8'h22, 3'b010, 8'h00},
        {2'd0, 8'h33, 3'b001, 8'h00},
        {2'd1, 8'h00, 3'b000, 8'hE1},
        {2'd2, 8'h00, 3'b000, 8'h11},
        {2'd1, 8'h00, 3'b000, 8'hE9},
        {2'd1, 8'h00, 3'b000, 8'hE1},
        {2'd2, 8'h00, 3'b000, 8'h22},
        {2'd1, 8'h00, 3'b000, 8'hE5},
        {2'd2, 8'h00, 3'b000, 8'h33},
        {2'd1, 8'h00, 3'b000, 8'hE0},
        {2'd1, 8'h00, 3'b000, 8'h60},
        {2'd0, 8'h44, 3'b100, 8'h00},
        {2'd0, 8'h55, 3'b011, 8'h00},
        {2'd1, 8'h00, 3'b000, 8'hF1},
        {2'd2, 8'h00, 3'b000, 8'h44},
        {2'd1, 8'h00, 3'b000, 8'hED},
        {2'd2, 8'h00, 3'b000, 8'h55},
        {2'd1, 8'h00, 3'b000, 8'hE0},
        {2'd1, 8'h00, 3'b000, 8'h60},
        {2'd2, 8'h00, 3'b000, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One bus/receiver cycle; rdata sampled before the committing edge
    task automatic step(input int op, input logic [7:0] d, input logic [2:0] tag,
                        input logic [ADDR_W-1:0] addr, output logic [31:0] rd);
        @(negedge clk);
        reg_addr = addr;
        case (op)
            0: begin rx_valid = 1'b1; rx_data = d; {rx_brk, rx_ferr, rx_perr} = tag; end
            1, 2: reg_rd = 1'b1;
            3: begin reg_wr = 1'b1; reg_wdata = d; end
            4: tx_load = 1'b1;
            5: tx_done = 1'b1;
            default: ;
        endcase
        #2 rd = reg_rdata;
        @(posedge clk);
        #1;
        rx_valid = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0;
        tx_load = 1'b0; tx_done = 1'b0;
        {rx_brk, rx_ferr, rx_perr} = 3'b000;
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] tag);
        logic [31:0] x;
        step(0, d, tag, '0, x);
    endtask

    task automatic rd_stat(output logic [31:0] v);
        step(1, 8'h00, 3'b000, ADDR_W'(1), v);
    endtask

    task automatic rd_data(output logic [31:0] v);
        step(2, 8'h00, 3'b000, ADDR_W'(0), v);
    endtask

    task automatic pulse(input int op, input logic [7:0] d);
        logic [31:0] x;
        step(op, d, 3'b000, '0, x);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd_stat(v);  check("R1 status after reset", v, 32'h60);
        rd_data(v);  check("R1 data read when empty", v, 32'h0);
        step(1, 8'h00, 3'b000, ADDR_W'(2), v); check("R1 unmapped address", v, 32'h0);

        // R2/R4/R7: table walk
        for (int i = 0; i < NVEC; i++) begin
            int op;
            op = int'(VEC[i][20:19]);
            if (op == 0) push(VEC[i][18:11], VEC[i][10:8]);
            else begin
                if (op == 1) rd_stat(v); else rd_data(v);
                check(op == 1 ? "R4/R7 status vector" : "R2 data vector", v, {24'd0, VEC[i][7:0]});
            end
        end

        // R3: overrun when queue full, R2 order preserved
        for (int i = 0; i < 9; i++) push(8'(i + 8'h80), 3'b000);
        rd_stat(v); check("R3 overrun set", v, 32'h63);
        rd_stat(v); check("R3 overrun cleared by status read", v, 32'h61);
        for (int i = 0; i < 8; i++) begin
            rd_data(v); check("R2 arrival order", v, 32'(i + 8'h80));
        end
        rd_stat(v); check("R2 data ready low after drain", v, 32'h60);

        // R5/R6: transmit holding and shift occupancy
        pulse(3, 8'hA5);
        rd_stat(v); check("R5 holding full after write", v, 32'h00);
        check("R5 holding byte on output", {23'd0, tx_thr_valid, tx_thr_data}, {23'd0, 1'b1, 8'hA5});
        pulse(4, 8'h00);
        rd_stat(v); check("R6 shift busy, holding empty", v, 32'h20);
        pulse(3, 8'h5A);
        pulse(5, 8'h00);
        rd_stat(v); check("R6 shift idle but holding full", v, 32'h00);
        pulse(4, 8'h00);
        rd_stat(v); check("R5 holding empty after load", v, 32'h20);
        pulse(5, 8'h00);
        rd_stat(v); check("R6 both empty", v, 32'h60);

        // R8: queue mode off
        @(negedge clk); fifo_en = 1'b0;
        push(8'h77, 3'b010);
        push(8'h78, 3'b000);
        rd_stat(v); check("R8 single entry, summary masked", v, 32'h6B);
        rd_data(v); check("R8 kept first character", v, 32'h77);
        rd_stat(v); check("R8 drained", v, 32'h60);
        @(negedge clk); fifo_en = 1'b1;
        rd_stat(v); check("R7 summary cleared after masked period", v, 32'h60);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule